// File: doc/BRIEF.md
# Program Memory Programming and Lock Controller

This block sits between the pin-level programming interface of a part and its on-chip program memory. From the levels on the reset pin, the program-store strobe, the address-latch/program pin, the external-access pin and two upper bits of the high port, it selects one of three operations. It can write one byte, read one byte back, or set a security lock. The cell address is twelve bits, built from the low port and the bottom nibble of the high port. The data byte comes in on its own input and goes out on a data port with an output enable.

A write needs a long low pulse on the address-latch/program pin, timed in oscillator ticks. The address and data must also have been steady for a minimum number of ticks before the pulse starts. A pulse that fails either rule leaves the array unchanged and raises an error flag.

Once the lock is set, readout is hidden, further writes are refused and external code execution is reported as disabled. Only a full erase clears the lock. The erase walks the whole array, one byte per tick, and leaves every byte at all ones.

Top module: `progmem_guard`

## Requirements
- R1: Program mode is decoded when mode_rst=1, store_n=0, hv_en=1, hi_port[7]=1 and hi_port[6]=0. A valid pulse then writes data_in into the cell at address {hi_port[3:0], lo_port}.
- R2: Verify mode is decoded when mode_rst=1, store_n=0, latch_prog_n=1, ext_en=1, hv_en=0, hi_port[7]=0 and hi_port[6]=0. hi_port[7] serves as an active-low read enable. The addressed byte appears on data_out with data_oe=1 three ticks after the pins are set. With hi_port[7]=1, data_oe stays 0.
- R3: Security-set mode uses the program-mode levels with hi_port[6]=1. A valid pulse in this mode sets locked.
- R4: A pulse counts as valid only if latch_prog_n stays low for a number of ticks between PULSE_MIN and PULSE_MAX inclusive. A shorter or longer pulse leaves the cell unchanged and sets err.
- R5: The address, data and mode select must be unchanged for at least SETUP_CYC ticks before latch_prog_n falls. Otherwise the pulse is rejected, the cell is unchanged and err is set.
- R6: While locked=1, verify mode keeps data_oe=0 and data_out=0.
- R7: While locked=1, a program pulse that would otherwise be valid is refused, and err is set.
- R8: ext_code_ok is 0 while locked=1 and 1 otherwise.
- R9: A one-tick pulse on erase raises erasing. Every byte is then written to 8'hFF, one per tick. When the sweep finishes, erasing falls and locked is cleared. Nothing else clears locked.
- R10: After reset, locked=0, err=0, data_oe=0, erasing=0 and ext_code_ok=1.
- R11: err is cleared when the next pulse begins, and stays clear while that pulse is in progress.
- R12: If the mode pins leave program or security-set mode during a pulse, the pulse is aborted. The cell is unchanged and err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rst | input | 1 | Reset pin level used for mode decode |
| store_n | input | 1 | Program-store strobe level |
| latch_prog_n | input | 1 | Address-latch pin level; active-low program pulse |
| ext_en | input | 1 | External-access pin logic level |
| hv_en | input | 1 | Programming voltage present on the external-access pin |
| lo_port | input | 8 | Low eight address bits |
| hi_port | input | 8 | [3:0] high address bits, [6] mode select, [7] mode/read enable |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Byte read back in verify mode (0 when not enabled) |
| data_oe | output | 1 | Data port output enable |
| erase | input | 1 | Full-erase request |
| erasing | output | 1 | Erase sweep in progress |
| locked | output | 1 | Security lock state |
| ext_code_ok | output | 1 | External code execution allowed |
| err | output | 1 | Last pulse was rejected or refused |

## Verification
The assertions assume that the mode pins and the erase request are synchronous to the tick clock, so every level is seen on a rising edge. They also assume the lock starts clear from reset, so a lock can be traced back to a set pulse. The bench changes every input only on falling clock edges. It holds the pins for whole ticks, and it keeps every pulse width and setup window several ticks from its limit, so the expected outcome of each pulse never depends on the exact edge at which a count saturates.

// File: rtl/progmem_pkg.sv
// Shared types of the program memory controller.
package progmem_pkg;

    // Operating mode selected by the pin levels.
    typedef enum logic [1:0] {
        PM_IDLE   = 2'd0,
        PM_PROG   = 2'd1,
        PM_VERIFY = 2'd2,
        PM_SECURE = 2'd3
    } pm_mode_e;

endpackage

// File: rtl/progmem_decode.sv
// progmem_decode: turns the sampled pin levels into an operating mode.
// Assumes: pins already synchronous to clk; purely combinational.
module progmem_decode
    import progmem_pkg::*;
(
    input  logic       mode_rst,
    input  logic       store_n,
    input  logic       latch_prog_n,
    input  logic       ext_en,
    input  logic       hv_en,
    input  logic [7:0] hi_port,
    output pm_mode_e   mode
);
    localparam int RD_BIT  = 7;
    localparam int SEL_BIT = 6;

    logic base_ok;
    logic unused_hi;

    assign unused_hi = ^hi_port[5:0];
    assign base_ok   = mode_rst && !store_n;

    // Mode table: the pulse pin is don't-care while high voltage is present.
    always_comb begin
        mode = PM_IDLE;
        if (base_ok) begin
            if (hv_en && hi_port[RD_BIT])
                mode = hi_port[SEL_BIT] ? PM_SECURE : PM_PROG;
            else if (!hv_en && ext_en && latch_prog_n &&
                     !hi_port[RD_BIT] && !hi_port[SEL_BIT])
                mode = PM_VERIFY;
        end
    end
endmodule

// File: rtl/progmem_pulse.sv
// progmem_pulse: qualifies a program pulse by setup time and width.
// Assumes: 'ad' holds select, address and data; 'arm' is true only in a
// write-capable mode. Emits one-tick start, ok and bad strobes; ad_q holds
// the bus captured when the pulse began.
module progmem_pulse #(
    parameter int AD_W      = 21,
    parameter int SETUP_CYC = 48,
    parameter int PULSE_MIN = 270000,
    parameter int PULSE_MAX = 330000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            prog_n,
    input  logic [AD_W-1:0] ad,
    output logic            start_p,
    output logic            ok_p,
    output logic            bad_p,
    output logic [AD_W-1:0] ad_q
);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam int WW = $clog2(PULSE_MAX + 2);
    localparam logic [SW-1:0] SETUP_L = SW'(SETUP_CYC);
    localparam logic [WW-1:0] MIN_L   = WW'(PULSE_MIN);
    localparam logic [WW-1:0] MAX_L   = WW'(PULSE_MAX);
    localparam logic [WW-1:0] SAT_L   = WW'(PULSE_MAX + 1);

    logic [AD_W-1:0] prev_ad;
    logic [SW-1:0]   stab_cnt;
    logic [WW-1:0]   width;
    logic            prev_prog_n;
    logic            in_pulse;
    logic            setup_ok;
    logic            moved;
    logic            same_ad;
    logic            fall;

    assign same_ad = (ad == prev_ad);
    assign fall    = arm && prev_prog_n && !prog_n && !in_pulse;

    // Track how long the bus has been steady, saturating at the setup limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ad     <= '0;
            stab_cnt    <= '0;
            prev_prog_n <= 1'b1;
        end else begin
            prev_ad     <= ad;
            prev_prog_n <= prog_n;
            if (!same_ad)
                stab_cnt <= '0;
            else if (stab_cnt != SETUP_L)
                stab_cnt <= stab_cnt + 1'b1;
        end
    end

    // Measure the pulse and judge it when it ends or is aborted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pulse <= 1'b0;
            setup_ok <= 1'b0;
            moved    <= 1'b0;
            width    <= '0;
            ad_q     <= '0;
            start_p  <= 1'b0;
            ok_p     <= 1'b0;
            bad_p    <= 1'b0;
        end else begin
            start_p <= 1'b0;
            ok_p    <= 1'b0;
            bad_p   <= 1'b0;
            if (fall) begin
                in_pulse <= 1'b1;
                start_p  <= 1'b1;
                width    <= WW'(1);
                setup_ok <= same_ad && (stab_cnt == SETUP_L);
                moved    <= 1'b0;
                ad_q     <= ad;
            end else if (in_pulse) begin
                if (!arm) begin
                    in_pulse <= 1'b0;
                    bad_p    <= 1'b1;
                end else if (!prog_n) begin
                    if (width != SAT_L)
                        width <= width + 1'b1;
                    if (!same_ad)
                        moved <= 1'b1;
                end else begin
                    in_pulse <= 1'b0;
                    if (setup_ok && !moved && width >= MIN_L && width <= MAX_L)
                        ok_p  <= 1'b1;
                    else
                        bad_p <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/progmem_array.sv
// progmem_array: behavioural byte array with one write port, an
// asynchronous read port and a sequential full-erase sweep to all ones.
// Assumes: erase requests during a sweep are ignored; the sweep owns the
// write port while it runs.
module progmem_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              erase_req,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              erasing,
    output logic              erase_last
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ptr;
    logic              wr;
    logic [ADDR_W-1:0] wa;
    logic [DATA_W-1:0] wd;

    assign erase_last = erasing && (ptr == LAST);
    assign wr = erasing || we;
    assign wa = erasing ? ptr : waddr;
    assign wd = erasing ? '1 : wdata;
    assign rdata = mem[raddr];

    // Erase sweep sequencer: one byte per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erasing <= 1'b0;
            ptr     <= '0;
        end else if (!erasing) begin
            if (erase_req) begin
                erasing <= 1'b1;
                ptr     <= '0;
            end
        end else begin
            ptr <= ptr + 1'b1;
            if (erase_last)
                erasing <= 1'b0;
        end
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr)
            mem[wa] <= wd;
    end
endmodule

// File: rtl/progmem_guard.sv
// progmem_guard: top of the program memory controller. Decodes the mode,
// qualifies program pulses, commits writes or the lock, and serves
// verify reads unless the lock is set.
// Assumes: all pins synchronous to clk (one tick = one oscillator period);
// the lock starts clear on reset, modelling an erased part.
module progmem_guard
    import progmem_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int LO_W      = 8,
    parameter int SETUP_CYC = 48,
    parameter int PULSE_MIN = 270000,
    parameter int PULSE_MAX = 330000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rst,
    input  logic              store_n,
    input  logic              latch_prog_n,
    input  logic              ext_en,
    input  logic              hv_en,
    input  logic [LO_W-1:0]   lo_port,
    input  logic [7:0]        hi_port,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              erase,
    output logic              erasing,
    output logic              locked,
    output logic              ext_code_ok,
    output logic              err
);
    localparam int HI_W = ADDR_W - LO_W;
    localparam int AD_W = 1 + ADDR_W + DATA_W;

    pm_mode_e          mode;
    logic              arm;
    logic              sel;
    logic [ADDR_W-1:0] addr;
    logic [AD_W-1:0]   ad_bus;
    logic [AD_W-1:0]   cap;
    logic              start_p;
    logic              ok_p;
    logic              bad_p;
    logic              prog_we;
    logic              erase_last;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] rd_q;
    logic              oe_q;

    progmem_decode u_dec (
        .mode_rst     (mode_rst),
        .store_n      (store_n),
        .latch_prog_n (latch_prog_n),
        .ext_en       (ext_en),
        .hv_en        (hv_en),
        .hi_port      (hi_port),
        .mode         (mode)
    );

    assign addr   = {hi_port[HI_W-1:0], lo_port};
    assign sel    = (mode == PM_SECURE);
    assign arm    = ((mode == PM_PROG) || (mode == PM_SECURE)) && !erasing;
    assign ad_bus = {sel, addr, data_in};

    progmem_pulse #(
        .AD_W      (AD_W),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_MIN (PULSE_MIN),
        .PULSE_MAX (PULSE_MAX)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .prog_n  (latch_prog_n),
        .ad      (ad_bus),
        .start_p (start_p),
        .ok_p    (ok_p),
        .bad_p   (bad_p),
        .ad_q    (cap)
    );

    assign prog_we = ok_p && !locked && !cap[AD_W-1];

    progmem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (prog_we),
        .waddr      (cap[DATA_W +: ADDR_W]),
        .wdata      (cap[DATA_W-1:0]),
        .erase_req  (erase),
        .raddr      (addr),
        .rdata      (rdata),
        .erasing    (erasing),
        .erase_last (erase_last)
    );

    // Lock bit and error flag bookkeeping on pulse outcomes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (erase_last)
                locked <= 1'b0;
            else if (ok_p && cap[AD_W-1])
                locked <= 1'b1;
            if (bad_p || (ok_p && locked))
                err <= 1'b1;
            else if (start_p)
                err <= 1'b0;
        end
    end

    // Registered verify read path, gated off by the lock and by erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
            rd_q <= '0;
        end else begin
            oe_q <= (mode == PM_VERIFY) && !locked && !erasing;
            rd_q <= rdata;
        end
    end

    assign data_oe     = oe_q;
    assign data_out    = oe_q ? rd_q : '0;
    assign ext_code_ok = !locked;
endmodule

// File: rtl/progmem_guard_chk.sv
// progmem_guard_chk: temporal checks on the controller's ports.
// Assumes: bound to progmem_guard; pins sampled on rising edges.
module progmem_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_rst,
    input logic       store_n,
    input logic       latch_prog_n,
    input logic       ext_en,
    input logic       hv_en,
    input logic [7:0] hi_port,
    input logic       data_oe,
    input logic       erasing,
    input logic       locked
);
    AST_LOCK_HIDES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $past(locked) |-> !data_oe); // R6

    AST_OE_NEEDS_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(mode_rst && !store_n && latch_prog_n && ext_en &&
                          !hv_en && !hi_port[7] && !hi_port[6])); // R2

    AST_UNLOCK_ONLY_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && $past(locked) |-> $past(erasing)); // R9

    AST_ERASE_ENDS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erasing) |-> !locked); // R9

    AST_NO_READ_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        erasing && $past(erasing) |-> !data_oe); // R9
endmodule

bind progmem_guard progmem_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_rst     (mode_rst),
    .store_n      (store_n),
    .latch_prog_n (latch_prog_n),
    .ext_en       (ext_en),
    .hv_en        (hv_en),
    .hi_port      (hi_port),
    .data_oe      (data_oe),
    .erasing      (erasing),
    .locked       (locked)
);

// File: tb/sim_progmem_guard.sv
// sim_progmem_guard: vector-table and directed bench for progmem_guard.
module sim_progmem_guard;
    localparam int CLK_P = 10;
    localparam int SETUP = 48;
    localparam int PMIN  = 20;
    localparam int PMAX  = 30;

    typedef struct packed {
        logic [11:0] a;
        logic [7:0]  d;
        logic [7:0]  w;
        logic [7:0]  h;
        logic        ok;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{12'h000, 8'hA5, 8'd25, 8'd60, 1'b1},
        '{12'hFFF, 8'h3C, 8'd25, 8'd60, 1'b1},
        '{12'h5A3, 8'h00, 8'd22, 8'd60, 1'b1},
        '{12'h123, 8'h77, 8'd10, 8'd60, 1'b0},
        '{12'h124, 8'h77, 8'd40, 8'd60, 1'b0},
        '{12'h125, 8'h11, 8'd25, 8'd5,  1'b0},
        '{12'h800, 8'h81, 8'd28, 8'd60, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_rst, store_n, latch_prog_n, ext_en, hv_en, erase;
    logic [7:0] lo_port, hi_port, data_in, data_out;
    logic       data_oe, erasing, locked, ext_code_ok, err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [7:0] shadow [4096];

    always #(CLK_P/2) clk = ~clk;

    progmem_guard #(
        .SETUP_CYC (SETUP),
        .PULSE_MIN (PMIN),
        .PULSE_MAX (PMAX)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .mode_rst (mode_rst), .store_n (store_n),
        .latch_prog_n (latch_prog_n), .ext_en (ext_en), .hv_en (hv_en),
        .lo_port (lo_port), .hi_port (hi_port), .data_in (data_in),
        .data_out (data_out), .data_oe (data_oe), .erase (erase),
        .erasing (erasing), .locked (locked), .ext_code_ok (ext_code_ok),
        .err (err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        mode_rst = 1'b0; store_n = 1'b1; latch_prog_n = 1'b1; ext_en = 1'b1;
        hv_en = 1'b0; hi_port = 8'h00; lo_port = 8'h00; data_in = 8'h00;
        erase = 1'b0;
    endtask

    // One program or security pulse; abort_at>0 drops hv_en mid pulse.
    task automatic pulse(input logic [11:0] a, input logic [7:0] d, input int w,
                         input int h, input logic sec, input int abort_at,
                         input bit mid_chk);
        @(negedge clk);
        mode_rst = 1'b1; store_n = 1'b0; hv_en = 1'b1; ext_en = 1'b1;
        latch_prog_n = 1'b1;
        hi_port = {1'b1, sec, 2'b00, a[11:8]}; lo_port = a[7:0]; data_in = d;
        repeat (h) @(negedge clk);
        latch_prog_n = 1'b0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (mid_chk && i == 5) chk("R11 err clear in pulse", err, 0);
            if (abort_at != 0 && i == abort_at) hv_en = 1'b0;
        end
        latch_prog_n = 1'b1;
        repeat (4) @(negedge clk);
        set_idle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input bit rd_en,
                      output logic [7:0] d, output logic oe);
        @(negedge clk);
        mode_rst = 1'b1; store_n = 1'b0; latch_prog_n = 1'b1; ext_en = 1'b1;
        hv_en = 1'b0; hi_port = {rd_en ? 1'b0 : 1'b1, 3'b000, a[11:8]};
        lo_port = a[7:0];
        repeat (3) @(negedge clk);
        d = data_out; oe = data_oe;
        set_idle();
    endtask

    task automatic do_erase();
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        chk("R9 erasing raised", erasing, 1);
        while (erasing) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 4096; i++) shadow[i] = 8'hFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        rst_n = 1'b0;
        set_idle();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 locked", locked, 0);
        chk("R10 err", err, 0);
        chk("R10 data_oe", data_oe, 0);
        chk("R10 erasing", erasing, 0);
        chk("R10 ext_code_ok", ext_code_ok, 1);

        do_erase();

        // Vector table: R1 writes, R4 width limits, R5 setup window
        for (int v = 0; v < NV; v++) begin
            pulse(VECS[v].a, VECS[v].d, int'(VECS[v].w), int'(VECS[v].h), 1'b0, 0, 1'b0);
            chk("R1 R4 R5 err after pulse", err, !VECS[v].ok);
            if (VECS[v].ok) shadow[VECS[v].a] = VECS[v].d;
            rd(VECS[v].a, 1'b1, d, oe);
            chk("R2 verify oe", oe, 1);
            chk("R1 R4 R5 cell content", d, shadow[VECS[v].a]);
        end

        // R2: read enable high means no drive
        rd(12'h000, 1'b0, d, oe);
        chk("R2 read enable high", oe, 0);

        // R11 / R12: error clears on next start; abort leaves cell unchanged
        pulse(12'h300, 8'h42, 10, 60, 1'b0, 0, 1'b0);
        chk("R4 short pulse err", err, 1);
        pulse(12'h300, 8'h42, 25, 60, 1'b0, 12, 1'b1);
        chk("R12 aborted pulse err", err, 1);
        rd(12'h300, 1'b1, d, oe);
        chk("R12 aborted cell", d, 8'hFF);

        // R3 / R8: security set
        pulse(12'h000, 8'h00, 25, 60, 1'b1, 0, 1'b0);
        chk("R3 locked", locked, 1);
        chk("R8 ext_code_ok", ext_code_ok, 0);
        // R6: readout hidden
        rd(12'h000, 1'b1, d, oe);
        chk("R6 oe while locked", oe, 0);
        chk("R6 data while locked", d, 8'h00);
        // R7: program refused
        pulse(12'h010, 8'h5A, 25, 60, 1'b0, 0, 1'b0);
        chk("R7 refused err", err, 1);
        chk("R7 still locked", locked, 1);

        // R9: full erase clears lock and array
        do_erase();
        chk("R9 unlocked", locked, 0);
        chk("R8 ext_code_ok after erase", ext_code_ok, 1);
        rd(12'h000, 1'b1, d, oe);
        chk("R9 cell 000", d, 8'hFF);
        rd(12'hFFF, 1'b1, d, oe);
        chk("R9 cell FFF", d, 8'hFF);
        rd(12'h010, 1'b1, d, oe);
        chk("R7 refused cell", d, 8'hFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule